// File: doc/BRIEF.md
# LIN Slave Automatic Baud Detector

This receive-side block lets a LIN slave node lock onto the bus bit rate without a programmed divider. It watches the serial input for a long dominant (low) break followed by a recessive delimiter, then times the 0x55 sync character against a prescaled reference tick. From that measurement it derives the bit period in ticks and uses it to receive the 8-bit data characters that follow, least significant bit first and without parity.

The controller is one state machine. Its states are `ST_OFF` (disabled), `ST_REFUSED` (enabled while configured as bus master), `ST_WAIT_BREAK`, `ST_WAIT_SYNC` (break and delimiter seen, waiting for the sync start edge), `ST_MEASURE` (timing the sync edges) and `ST_LOCKED` (receiving data). The transitions are as follows. Enable low forces `ST_OFF`. Master configuration forces `ST_REFUSED`. `ST_OFF` and `ST_REFUSED` move to `ST_WAIT_BREAK` once enabled as a slave. A completed break moves any active state to `ST_WAIT_SYNC`. A falling edge moves `ST_WAIT_SYNC` to `ST_MEASURE`. A good fifth falling edge moves `ST_MEASURE` to `ST_LOCKED`. A spacing mismatch, an out-of-range period or a spacing timeout returns `ST_MEASURE` to `ST_WAIT_BREAK`.

A second state machine, in the byte receiver, steps through `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`. The input passes through a two-flop synchroniser and an optional glitch filter. Status events set sticky flags, raise a one-cycle interrupt pulse, and are cleared by a strobe.

Top module: `lin_autobaud_rx`

## Requirements
- R1: After reset `status`, `bit_period`, `rx_data`, `rx_valid` and `stat_irq` are all zero.
- R2: While `enable` and `master_cfg` are both high, the block refuses to operate: status bit 5 (mode error) is set once, and no break, lock or data is reported.
- R3: A low level lasting at least `BRK_TICKS` ticks that is followed by a rising edge sets status bit 0 (break seen) and arms sync measurement.
- R4: A low level shorter than `BRK_TICKS` ticks is not a break: bit 0 stays clear and a sync character that follows produces no lock.
- R5: After a break, the time from the first to the fifth falling edge of the sync character (eight bit times), divided by 8, is loaded into `bit_period`, and status bit 1 (locked) is set.
- R6: If any later falling-edge spacing in the sync character differs from the first spacing by more than the first spacing shifted right by `TOL_SHIFT`, status bit 2 (sync error) is set, `bit_period` is unchanged, and a new break is awaited.
- R7: A measured period below `PER_MIN` or above `PER_MAX`, or an edge spacing that reaches 2.5 × `PER_MAX` ticks, sets status bit 3 (range error) without a lock.
- R8: Once locked, each character (start bit low, 8 data bits LSB first, stop bit) is sampled at bit centres. The start bit is sampled half a period after its falling edge, and the byte is output on `rx_data` with a one-cycle `rx_valid` pulse.
- R9: A stop bit sampled low sets status bit 4 (framing error), and the byte is still delivered.
- R10: With `filt_en` high, an input level change that lasts fewer than `FILT_LEN` ticks is ignored.
- R11: Each status event produces a one-cycle `stat_irq` pulse in the cycle its flag appears. `stat_clr` zeroes all flags without raising `stat_irq`, and an event in the same cycle as a clear wins.
- R12: With `enable` low, line activity changes neither the status nor `bit_period`, and no byte is delivered.
- R13: A new break while locked restarts measurement, and a subsequent sync at another rate replaces `bit_period`.
- R14: All timing counts only cycles with `tick` high, so the measured period is in ticks regardless of the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled reference enable, one cycle per reference tick |
| rx_in | input | 1 | Raw serial receive line |
| enable | input | 1 | Block enable |
| master_cfg | input | 1 | Node configured as bus master (mode refused) |
| filt_en | input | 1 | Glitch filter enable |
| stat_clr | input | 1 | Clear all status flags |
| bit_period | output | $clog2(PER_MAX+1) | Measured bit period in ticks |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse with a new byte |
| status | output | 6 | Sticky flags: 0 break, 1 locked, 2 sync error, 3 range error, 4 framing error, 5 mode error |
| stat_irq | output | 1 | One-cycle pulse on any status event |

## Verification
A wrong controller state shows within one character time. A missed transition to `ST_WAIT_SYNC` leaves status bit 0 clear right after the delimiter edge. A stuck `ST_MEASURE` leaves bit 1 clear and `bit_period` stale after the fifth sync falling edge. A wrong sampling offset or shift direction in the byte receiver appears as a corrupted or bit-reversed `rx_data` at the stop-bit centre of the first data byte. Counter errors in the measurement path show as a `bit_period` off from the driven rate, or as spurious sync or range flags, as soon as the sync character ends.

// File: rtl/lin_ab_pkg.sv
`timescale 1ns/1ps
package lin_ab_pkg;

    localparam int STAT_W = 6;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_REFUSED,
        ST_WAIT_BREAK,
        ST_WAIT_SYNC,
        ST_MEASURE,
        ST_LOCKED
    } ab_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // first member is the most significant status bit
    typedef struct packed {
        logic mode_err;
        logic frame_err;
        logic range_err;
        logic sync_err;
        logic lock;
        logic brk;
    } ab_events_t;

endpackage

// File: rtl/lin_ab_rxfilt.sv
`timescale 1ns/1ps
module lin_ab_rxfilt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    input  logic filt_en,
    output logic rx_o,
    output logic fall,
    output logic rise
);
    localparam int FCW = $clog2(FILT_LEN + 1);

    logic [1:0]     sy_q;
    logic           rx_d;
    logic [FCW-1:0] fcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= 2'b11;
            rx_o <= 1'b1;
            rx_d <= 1'b1;
            fcnt <= '0;
        end else begin
            sy_q <= {sy_q[0], rx_in};
            rx_d <= rx_o;
            if (!filt_en) begin
                rx_o <= sy_q[1];
                fcnt <= '0;
            end else if (sy_q[1] == rx_o) begin
                fcnt <= '0;
            end else if (tick) begin
                if (fcnt == FCW'(FILT_LEN - 1)) begin
                    rx_o <= sy_q[1];
                    fcnt <= '0;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end
        end
    end

    assign fall = rx_d & ~rx_o;
    assign rise = ~rx_d & rx_o;

    // R10: while filtering, the output only moves after a full qualifying run
    p_filter_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && $past(filt_en) && !$stable(rx_o))
            |-> ($past(sy_q[1]) == rx_o && $past(fcnt) == FCW'(FILT_LEN - 1)));

endmodule

// File: rtl/lin_ab_brkdet.sv
`timescale 1ns/1ps
module lin_ab_brkdet #(
    parameter int BRK_TICKS = 36674
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_f,
    input  logic rise,
    output logic brk_end
);
    localparam int BW = $clog2(BRK_TICKS + 1);

    logic [BW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (rx_f) begin
            low_cnt <= '0;
        end else if (tick && low_cnt != BW'(BRK_TICKS)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign brk_end = rise && (low_cnt == BW'(BRK_TICKS));

    // R3: the low-run counter saturates at the break threshold
    p_low_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= BW'(BRK_TICKS));

    // R3: a break end only coincides with the line returning high
    p_brk_on_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> (rx_f && $past(!rx_f)));

endmodule

// File: rtl/lin_ab_bytercv.sv
`timescale 1ns/1ps
module lin_ab_bytercv
    import lin_ab_pkg::*;
#(
    parameter int PW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          rx_f,
    input  logic          fall,
    input  logic [PW-1:0] period,
    output logic [7:0]    data,
    output logic          valid,
    output logic          ferr
);
    rx_state_e     st, st_nx;
    logic [PW-1:0] cnt;
    logic [PW-1:0] target;
    logic [7:0]    sh;
    logic [2:0]    bidx;
    logic          due;

    assign due = tick && (cnt == target - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (fall) st_nx = RX_START;
            RX_START: if (due) st_nx = rx_f ? RX_IDLE : RX_DATA;
            RX_DATA:  if (due && bidx == 3'd7) st_nx = RX_STOP;
            RX_STOP:  if (due) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
        if (!run) st_nx = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            target <= '0;
            sh     <= '0;
            bidx   <= '0;
            data   <= '0;
            valid  <= 1'b0;
            ferr   <= 1'b0;
        end else begin
            valid <= 1'b0;
            ferr  <= 1'b0;
            if (!run || st == RX_IDLE) begin
                cnt    <= '0;
                target <= period >> 1;
                bidx   <= '0;
            end else if (due) begin
                cnt    <= '0;
                target <= period;
                unique case (st)
                    RX_DATA: begin
                        sh   <= {rx_f, sh[7:1]};
                        bidx <= bidx + 1'b1;
                    end
                    RX_STOP: begin
                        data  <= sh;
                        valid <= 1'b1;
                        ferr  <= ~rx_f;
                    end
                    default: ;
                endcase
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: a byte strobe never lasts more than one cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R12: when not running the receiver falls back to idle
    p_idle_when_stopped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st == RX_IDLE));

endmodule

// File: rtl/lin_autobaud_rx.sv
`timescale 1ns/1ps
module lin_autobaud_rx
    import lin_ab_pkg::*;
#(
    parameter int PER_MIN   = 62,
    parameter int PER_MAX   = 5000,
    parameter int BRK_TICKS = 36674,
    parameter int FILT_LEN  = 3,
    parameter int TOL_SHIFT = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         rx_in,
    input  logic                         enable,
    input  logic                         master_cfg,
    input  logic                         filt_en,
    input  logic                         stat_clr,
    output logic [$clog2(PER_MAX+1)-1:0] bit_period,
    output logic [7:0]                   rx_data,
    output logic                         rx_valid,
    output logic [STAT_W-1:0]            status,
    output logic                         stat_irq
);
    localparam int PW       = $clog2(PER_MAX + 1);
    localparam int SPAN_LIM = 2 * PER_MAX + PER_MAX / 2;
    localparam int SW       = $clog2(SPAN_LIM + 1);
    localparam int TW       = SW + 2;

    logic rx_f, fall, rise, brk_end, rcv_ferr;

    lin_ab_rxfilt #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .filt_en(filt_en), .rx_o(rx_f), .fall(fall), .rise(rise)
    );

    lin_ab_brkdet #(.BRK_TICKS(BRK_TICKS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_f(rx_f),
        .rise(rise), .brk_end(brk_end)
    );

    ab_state_e state, state_nx;

    lin_ab_bytercv #(.PW(PW)) u_rcv (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(state == ST_LOCKED),
        .rx_f(rx_f), .fall(fall), .period(bit_period),
        .data(rx_data), .valid(rx_valid), .ferr(rcv_ferr)
    );

    // sync measurement datapath
    logic [SW-1:0]     span, s0, sp_now, diff, tol;
    logic [TW-1:0]     total, tot_nx, per_calc;
    logic [1:0]        ecnt;
    logic              spc_bad, per_ok, timeout;
    ab_events_t        ev;
    logic [STAT_W-1:0] ev_vec;

    assign sp_now   = span + SW'(tick);
    assign diff     = (sp_now > s0) ? (sp_now - s0) : (s0 - sp_now);
    assign tol      = s0 >> TOL_SHIFT;
    assign spc_bad  = diff > tol;
    assign tot_nx   = total + TW'(sp_now);
    assign per_calc = tot_nx >> 3;
    assign per_ok   = (per_calc >= TW'(PER_MIN)) && (per_calc <= TW'(PER_MAX));
    assign timeout  = span >= SW'(SPAN_LIM);
    assign ev_vec   = ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        ev       = '0;
        if (!enable) begin
            state_nx = ST_OFF;
        end else if (master_cfg) begin
            state_nx    = ST_REFUSED;
            ev.mode_err = (state != ST_REFUSED);
        end else if (brk_end && state != ST_OFF && state != ST_REFUSED) begin
            state_nx = ST_WAIT_SYNC;
            ev.brk   = 1'b1;
        end else begin
            unique case (state)
                ST_OFF, ST_REFUSED: state_nx = ST_WAIT_BREAK;
                ST_WAIT_BREAK:      state_nx = ST_WAIT_BREAK;
                ST_WAIT_SYNC:       if (fall) state_nx = ST_MEASURE;
                ST_MEASURE: begin
                    if (timeout) begin
                        state_nx     = ST_WAIT_BREAK;
                        ev.range_err = 1'b1;
                    end else if (fall) begin
                        if (ecnt != 2'd0 && spc_bad) begin
                            state_nx    = ST_WAIT_BREAK;
                            ev.sync_err = 1'b1;
                        end else if (ecnt == 2'd3) begin
                            if (per_ok) begin
                                state_nx = ST_LOCKED;
                                ev.lock  = 1'b1;
                            end else begin
                                state_nx     = ST_WAIT_BREAK;
                                ev.range_err = 1'b1;
                            end
                        end
                    end
                end
                ST_LOCKED:          state_nx = ST_LOCKED;
                default:            state_nx = ST_OFF;
            endcase
        end
        ev.frame_err = rcv_ferr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span       <= '0;
            s0         <= '0;
            total      <= '0;
            ecnt       <= '0;
            bit_period <= '0;
            status     <= '0;
            stat_irq   <= 1'b0;
        end else begin
            stat_irq <= |ev_vec;
            status   <= (stat_clr ? '0 : status) | ev_vec;
            if (state != ST_MEASURE) begin
                span  <= '0;
                s0    <= '0;
                total <= '0;
                ecnt  <= '0;
            end else if (fall) begin
                span  <= '0;
                ecnt  <= ecnt + 1'b1;
                total <= tot_nx;
                if (ecnt == 2'd0) s0 <= sp_now;
            end else if (tick) begin
                span <= span + 1'b1;
            end
            if (ev.lock) bit_period <= PW'(per_calc);
        end
    end

    // R11: an interrupt pulse always comes with a visible flag
    p_irq_has_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_irq |-> (status != '0));

    // R11: a clear with no competing event empties the status
    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && ev_vec == '0) |=> (status == '0));

    // R7: a lock only ever loads a period inside the supported range
    p_lock_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev.lock |=> (bit_period >= PW'(PER_MIN) && bit_period <= PW'(PER_MAX)));

    // R2: master configuration parks the controller in the refused state
    p_master_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && master_cfg) |=> (state == ST_REFUSED));

    // R12: disabling returns the controller to off
    p_off_when_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_OFF));

endmodule

// File: tb/tb_lin_autobaud_rx.sv
`timescale 1ns/1ps
module tb_lin_autobaud_rx;
    localparam int PMIN = 4;
    localparam int PMAX = 40;
    localparam int BRK  = 440;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rx = 1'b1;
    logic       enable = 1'b0, master = 1'b0, filt = 1'b0, clr = 1'b0;
    logic [5:0] bit_period;
    logic [7:0] rx_data;
    logic       rx_valid, stat_irq;
    logic [5:0] status;

    lin_autobaud_rx #(.PER_MIN(PMIN), .PER_MAX(PMAX), .BRK_TICKS(BRK),
                      .FILT_LEN(3), .TOL_SHIFT(3)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx), .enable(enable),
        .master_cfg(master), .filt_en(filt), .stat_clr(clr),
        .bit_period(bit_period), .rx_data(rx_data), .rx_valid(rx_valid),
        .status(status), .stat_irq(stat_irq)
    );

    always #2.5 clk = ~clk;

    int tick_div = 1;
    always @(negedge clk) begin
        if (tick_div == 1) tick <= 1'b1;
        else               tick <= ~tick;
    end

    // monitor: byte capture and interrupt count
    logic [7:0] cap [64];
    int cap_total = 0, irq_n = 0, cyc = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                cap[cap_total % 64] = rx_data;
                cap_total++;
            end
            if (stat_irq) irq_n++;
        end
    end

    int nchk = 0, nfail = 0;
    int cap_base = 0, irq_base = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog: run did not finish (act=hung exp=done)");
            $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int ticks);
        rx = lvl;
        repeat (ticks * tick_div) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int p, input logic stop);
        hold(1'b0, p);
        for (int i = 0; i < 8; i++) hold(b[i], p);
        hold(stop, p);
        hold(1'b1, 3 * p + 10);
    endtask

    task automatic send_break();
        hold(1'b0, 450);
        hold(1'b1, 30);
    endtask

    task automatic prep();
        enable = 1'b0;
        repeat (4) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        cap_base = cap_total;
        irq_base = irq_n;
    endtask

    // vector: period, data byte, stop level, expected status
    localparam logic [31:0] VEC [6] = '{
        {8'd4,  8'hA5, 8'd1, 8'h03},
        {8'd10, 8'h01, 8'd1, 8'h03},
        {8'd17, 8'h80, 8'd1, 8'h03},
        {8'd25, 8'h3C, 8'd0, 8'h13},
        {8'd40, 8'hFF, 8'd1, 8'h03},
        {8'd13, 8'h00, 8'd1, 8'h03}
    };

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status, 0);
        check("R1 bit_period", bit_period, 0);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 stat_irq", stat_irq, 0);
        check("R1 rx_data", rx_data, 0);

        // table walk: R3 R5 R8 R9 R11
        for (int i = 0; i < 6; i++) begin
            int p;
            logic [7:0] d;
            p = int'(VEC[i][31:24]);
            d = VEC[i][23:16];
            prep();
            send_break();
            send_frame(8'h55, p, 1'b1);
            send_frame(d, p, VEC[i][8]);
            check("R5 measured period", bit_period, p);
            check("R8 byte count", cap_total - cap_base, 1);
            check("R8 byte value LSB first", cap[cap_base % 64], d);
            check("R3/R9 status flags", status, VEC[i][7:0]);
            check("R11 one irq per event", irq_n - irq_base, $countones(VEC[i][7:0]));
        end

        // R12 disabled: nothing happens
        enable = 1'b0;
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        cap_base = cap_total;
        send_break();
        send_frame(8'h55, 10, 1'b1);
        send_frame(8'h5A, 10, 1'b1);
        check("R12 status while disabled", status, 0);
        check("R12 no bytes while disabled", cap_total - cap_base, 0);
        check("R12 period kept", bit_period, 13);

        // R2 master refused
        irq_base = irq_n;
        master = 1'b1;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 mode error flag", status, 6'h20);
        check("R11 irq for mode error", irq_n - irq_base, 1);
        send_break();
        send_frame(8'h55, 10, 1'b1);
        check("R2 no break or lock as master", status, 6'h20);
        check("R2 period kept as master", bit_period, 13);
        master = 1'b0;

        // R4 short low is not a break
        prep();
        hold(1'b0, 300);
        hold(1'b1, 30);
        send_frame(8'h55, 10, 1'b1);
        check("R4 short low ignored", status, 0);
        check("R4 period kept", bit_period, 13);

        // R6 uneven sync spacing
        prep();
        send_break();
        hold(1'b0, 10); hold(1'b1, 10); hold(1'b0, 10); hold(1'b1, 10);
        hold(1'b0, 10); hold(1'b1, 20); hold(1'b0, 10); hold(1'b1, 10);
        hold(1'b0, 10); hold(1'b1, 40);
        check("R6 sync error flag", status, 6'h05);
        check("R6 period kept", bit_period, 13);

        // R7 too fast and too slow
        prep();
        send_break();
        send_frame(8'h55, 3, 1'b1);
        check("R7 too fast range error", status, 6'h09);
        prep();
        send_break();
        send_frame(8'h55, 45, 1'b1);
        check("R7 too slow range error", status, 6'h09);
        check("R7 period kept", bit_period, 13);

        // R10 filter suppresses short glitch
        filt = 1'b1;
        prep();
        send_break();
        hold(1'b1, 20); hold(1'b0, 2); hold(1'b1, 30);
        send_frame(8'h55, 10, 1'b1);
        send_frame(8'hC3, 10, 1'b1);
        check("R10 filtered lock", status, 6'h03);
        check("R10 filtered period", bit_period, 10);
        check("R10 filtered byte", cap[cap_base % 64], 8'hC3);
        filt = 1'b0;
        prep();
        send_break();
        hold(1'b1, 20); hold(1'b0, 2); hold(1'b1, 30);
        send_frame(8'h55, 10, 1'b1);
        check("R10 unfiltered glitch breaks sync", status, 6'h05);

        // R11 clear gives zero and no irq
        irq_base = irq_n;
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        @(negedge clk);
        check("R11 clear empties status", status, 0);
        check("R11 clear raises no irq", irq_n - irq_base, 0);

        // R13 resync while locked
        prep();
        send_break();
        send_frame(8'h55, 10, 1'b1);
        send_break();
        send_frame(8'h55, 20, 1'b1);
        send_frame(8'h96, 20, 1'b1);
        check("R13 new period", bit_period, 20);
        check("R13 byte count", cap_total - cap_base, 2);
        check("R13 break seen as null byte", cap[cap_base % 64], 8'h00);
        check("R13 byte at new rate", cap[(cap_base + 1) % 64], 8'h96);
        check("R13 status", status, 6'h13);

        // R14 half-rate tick
        tick_div = 2;
        prep();
        send_break();
        send_frame(8'h55, 10, 1'b1);
        send_frame(8'h4B, 10, 1'b1);
        tick_div = 1;
        check("R14 period in ticks", bit_period, 10);
        check("R14 byte at half tick", cap[cap_base % 64], 8'h4B);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule